// File: doc/BRIEF.md
# Dual-Bit Serial Write Master

This block is a serial bus master that pushes bytes from a host stream out to one of two peripheral selects. In its normal mode it clocks one bit per serial clock on a single data line. In its fast-write mode it clocks two bits per serial clock. The second bit of each pair goes out on an auxiliary line that otherwise idles high as a spare third select. While a byte is shifted out, the block samples the input data line on every rising serial clock and hands the collected bits back as a received word.

The serial clock rate is derived from the system clock by a divider. The divider is captured when each byte is accepted. Zero is promoted to one, because with no wait states the first bit read back cannot be trusted. The host offers bytes on a valid/ready stream. `tx_ready` is high only when the block is idle and any required gap after a select release has elapsed. A byte is taken on the clock edge where `tx_valid` and `tx_ready` are both high, and the host must keep `tx_valid`, `tx_data` and the configuration pins steady until then. The received-word output is a one-cycle `rx_valid` pulse with no back-pressure, so the host must take it in that cycle. A hold input keeps the select asserted between consecutive bytes of one message. When the select is released, a minimum gap of 100 ns, counted in system clocks, passes before the next assertion.

Top module: `dbs_master`

## Requirements
- R1: In normal mode (`cfg_fast`=0), a byte produces exactly 8 rising serial clock edges, and `mosi` carries bit 7 first and bit 0 last.
- R2: In fast-write mode (`cfg_fast`=1), a byte produces exactly 4 rising edges, carrying the bit pairs (7,6), (5,4), (3,2) and (1,0) in that order. The higher bit of each pair is on `mosi` and the lower bit is on `aux`.
- R3: `mosi` and `aux` change only while `sclk` is low, and they hold steady for the whole high half of each serial clock period.
- R4: With `cfg_sel_hi`=0, select index 2 drives `sel1_n` low and any other index drives `sel0_n` low during the transfer. With `cfg_sel_hi`=1, both selects stay high. The two selects are never low together.
- R5: Unless `cfg_hold` is 1, both selects return high when a byte completes. With `cfg_hold`=1, the select stays low across bytes, and it returns high once `cfg_hold` drops while the block is idle.
- R6: Each half of the serial clock lasts max(`cfg_div`,1)+1 system clocks, so `cfg_div`=0 behaves as 1.
- R7: `miso` is sampled on each rising serial edge and shifted in from bit 0 upward. One cycle after the last high half ends, `rx_valid` pulses for exactly one cycle with the word. In normal mode the word is all 8 samples, with the first sample in bit 7. In fast mode it is the 4 samples in bits 3:0, with the first in bit 3 and bits 7:4 zero.
- R8: `tx_ready` is low from the cycle after acceptance until the byte completes, and a second byte is never taken during a transfer.
- R9: After the selects are released, both stay high for at least ceil(100 ns × system clock MHz) system clocks (10 at the default 100 MHz) before either is asserted again.
- R10: After reset, `sclk` and `mosi` are low, `aux`, `sel0_n` and `sel1_n` are high, `rx_valid` is low and `tx_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_div | input | DIV_W | Serial clock divider, captured per byte |
| cfg_fast | input | 1 | 1 selects two bits per serial clock |
| cfg_sel | input | SEL_W | Select index; 2 picks the second select |
| cfg_sel_hi | input | 1 | 1 selects active-high polarity (no select driven low) |
| cfg_hold | input | 1 | Keep the select asserted after the byte |
| tx_valid | input | 1 | Host byte valid |
| tx_ready | output | 1 | Block can accept a byte |
| tx_data | input | W | Byte to send |
| rx_valid | output | 1 | One-cycle pulse with received word |
| rx_data | output | W | Received word |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| aux | output | 1 | Second data bit in fast mode, else high |
| sel0_n | output | 1 | First select, active low |
| sel1_n | output | 1 | Second select, active low |
| miso | input | 1 | Serial data in |

## Verification
The byte path is driven with asymmetric patterns such as 0xA5 and 0x3C in normal mode, which expose bit-order reversal, dropped or extra clocks and an off-by-one in the shift count. In fast mode it is driven with 0xB4, whose pairs differ between the `mosi` and `aux` streams, so a swapped pair or a missing shift by two shows up. A distinct `miso` pattern in each transfer separates the received-word assembly from the transmit path, and divider values 0, 1 and 3 tell the forced minimum apart from a plain divider. Select-index 2, active-high polarity, held selects and back-to-back bytes with a release between them check the select decode and the enforced idle gap.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2
  } dbs_state_e;

  // select index that steers to the second select pin
  localparam int ALT_SEL_IDX = 2;
endpackage

// File: rtl/dbs_divider.sv
module dbs_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIV_W-1:0] div_in,
  input  logic             run,
  output logic             half_end
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] cnt_q;

  // a zero divider is promoted to one
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= DIV_W'(1);
    end else if (load) begin
      div_q <= (div_in == '0) ? DIV_W'(1) : div_in;
    end
  end

  assign half_end = run && (cnt_q == div_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || half_end) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end
endmodule

// File: rtl/dbs_shifter.sv
module dbs_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         fast_in,
  input  logic [W-1:0] data_in,
  input  logic         adv,
  input  logic         sample,
  input  logic         miso,
  output logic         mosi_bit,
  output logic         aux_bit,
  output logic         last,
  output logic [W-1:0] rx_word
);
  localparam int CW = $clog2(W);

  logic [W-1:0]  tx_q;
  logic [W-1:0]  rx_q;
  logic [CW-1:0] left_q;
  logic          fast_q;
  logic [W-1:0]  tx_next;

  // shift distance is chosen by the mode
  generate
    if (W >= 2) begin : g_shift
      always_comb begin
        if (fast_q) tx_next = {tx_q[W-3:0], 2'b00};
        else        tx_next = {tx_q[W-2:0], 1'b0};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_q   <= '0;
      left_q <= '0;
      fast_q <= 1'b0;
    end else if (load) begin
      tx_q   <= data_in;
      fast_q <= fast_in;
      left_q <= fast_in ? CW'(W/2 - 1) : CW'(W - 1);
    end else if (adv) begin
      tx_q   <= tx_next;
      left_q <= left_q - CW'(1);
    end
  end

  // cleared per byte so fast mode leaves the upper half zero
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_q <= '0;
    end else if (load) begin
      rx_q <= '0;
    end else if (sample) begin
      rx_q <= {rx_q[W-2:0], miso};
    end
  end

  assign mosi_bit = tx_q[W-1];
  assign aux_bit  = fast_q ? tx_q[W-2] : 1'b1;
  assign last     = (left_q == '0);
  assign rx_word  = rx_q;
endmodule

// File: rtl/dbs_selctl.sv
module dbs_selctl #(
  parameter int SEL_W   = 2,
  parameter int GAP_CYC = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             grab,
  input  logic             drop,
  input  logic [SEL_W-1:0] idx,
  input  logic             pol_hi,
  output logic             sel0_n,
  output logic             sel1_n,
  output logic             held,
  output logic             gap_busy
);
  localparam int GW = $clog2(GAP_CYC + 1);

  logic          on_q;
  logic          alt_q;
  logic          hi_q;
  logic [GW-1:0] gap_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      on_q  <= 1'b0;
      alt_q <= 1'b0;
      hi_q  <= 1'b0;
      gap_q <= '0;
    end else begin
      if (grab) begin
        on_q  <= 1'b1;
        alt_q <= (idx == SEL_W'(dbs_pkg::ALT_SEL_IDX));
        hi_q  <= pol_hi;
      end else if (drop) begin
        on_q  <= 1'b0;
      end
      if (!grab && drop) begin
        gap_q <= GW'(GAP_CYC);
      end else if (gap_q != '0) begin
        gap_q <= gap_q - GW'(1);
      end
    end
  end

  assign sel0_n   = !(on_q && !hi_q && !alt_q);
  assign sel1_n   = !(on_q && !hi_q && alt_q);
  assign held     = on_q;
  assign gap_busy = (gap_q != '0);
endmodule

// File: rtl/dbs_master.sv
module dbs_master
  import dbs_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int W       = 8,
  parameter int SEL_W   = 2,
  parameter int SYS_MHZ = 100,
  parameter int GAP_NS  = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             cfg_fast,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic             cfg_sel_hi,
  input  logic             cfg_hold,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic [W-1:0]     tx_data,
  output logic             rx_valid,
  output logic [W-1:0]     rx_data,
  output logic             sclk,
  output logic             mosi,
  output logic             aux,
  output logic             sel0_n,
  output logic             sel1_n,
  input  logic             miso
);
  localparam int GAP_CYC = (GAP_NS * SYS_MHZ + 999) / 1000;

  dbs_state_e   state_q;
  logic         busy;
  logic         accept;
  logic         half_end;
  logic         to_high;
  logic         end_high;
  logic         fin;
  logic         adv;
  logic         drop;
  logic         held;
  logic         gap_busy;
  logic         mosi_bit;
  logic         aux_bit;
  logic         last;
  logic [W-1:0] rx_word;

  assign busy     = (state_q != ST_IDLE);
  assign tx_ready = !busy && !gap_busy;
  assign accept   = tx_valid && tx_ready;
  assign to_high  = (state_q == ST_LOW) && half_end;
  assign end_high = (state_q == ST_HIGH) && half_end;
  assign fin      = end_high && last;
  assign adv      = end_high && !last;
  assign drop     = (fin && !cfg_hold) || (!busy && held && !cfg_hold);

  dbs_divider #(.DIV_W(DIV_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .div_in   (cfg_div),
    .run      (busy),
    .half_end (half_end)
  );

  dbs_shifter #(.W(W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .fast_in  (cfg_fast),
    .data_in  (tx_data),
    .adv      (adv),
    .sample   (to_high),
    .miso     (miso),
    .mosi_bit (mosi_bit),
    .aux_bit  (aux_bit),
    .last     (last),
    .rx_word  (rx_word)
  );

  dbs_selctl #(.SEL_W(SEL_W), .GAP_CYC(GAP_CYC)) u_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .grab     (accept),
    .drop     (drop),
    .idx      (cfg_sel),
    .pol_hi   (cfg_sel_hi),
    .sel0_n   (sel0_n),
    .sel1_n   (sel1_n),
    .held     (held),
    .gap_busy (gap_busy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept)   state_q <= ST_LOW;
        ST_LOW:  if (half_end) state_q <= ST_HIGH;
        ST_HIGH: if (half_end) state_q <= last ? ST_IDLE : ST_LOW;
        default:               state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else begin
      rx_valid <= fin;
      if (fin) rx_data <= rx_word;
    end
  end

  assign sclk = (state_q == ST_HIGH);
  assign mosi = busy ? mosi_bit : 1'b0;
  assign aux  = busy ? aux_bit : 1'b1;
endmodule

// File: rtl/dbs_master_chk.sv
module dbs_master_chk #(
  parameter int GAP_CYC = 10
) (
  input logic clk,
  input logic rst_n,
  input logic sclk,
  input logic mosi,
  input logic aux,
  input logic sel0_n,
  input logic sel1_n,
  input logic tx_ready,
  input logic rx_valid
);
  localparam int RW = $clog2(GAP_CYC + 1);

  logic [RW-1:0] idle_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle_run <= RW'(GAP_CYC);
    end else if (sel0_n && sel1_n) begin
      if (idle_run != RW'(GAP_CYC)) idle_run <= idle_run + RW'(1);
    end else begin
      idle_run <= '0;
    end
  end

  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> ($stable(mosi) && $stable(aux))); // R3

  AST_SEL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    (sel0_n || sel1_n)); // R4

  AST_DIV_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> $past(sclk, 2)); // R6

  AST_RX_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R7

  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> !sclk); // R8

  AST_SEL_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sel0_n && sel1_n) |-> (idle_run == RW'(GAP_CYC))); // R9
endmodule

bind dbs_master dbs_master_chk #(.GAP_CYC(GAP_CYC)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .sclk     (sclk),
  .mosi     (mosi),
  .aux      (aux),
  .sel0_n   (sel0_n),
  .sel1_n   (sel1_n),
  .tx_ready (tx_ready),
  .rx_valid (rx_valid)
);

// File: tb/dbs_master_tb_top.sv
module dbs_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int GAP_EXP    = 10;  // ceil(100 ns * 100 MHz)

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cfg_div = 8'd1;
  logic       cfg_fast = 1'b0;
  logic [1:0] cfg_sel = 2'd0;
  logic       cfg_sel_hi = 1'b0;
  logic       cfg_hold = 1'b0;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic [7:0] tx_data = 8'h00;
  logic       rx_valid;
  logic [7:0] rx_data;
  logic       sclk, mosi, aux, sel0_n, sel1_n, miso;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // written only by tasks
  logic [7:0] miso_pat = 8'h00;
  logic       e0 = 1'b1, e1 = 1'b1;
  int         arm_tok = 0;

  // written only by the monitor
  int seen_tok = 0;
  int edges = 0, stab_err = 0, sel_bad = 0, sel_rise = 0, ready_busy = 0;
  int rx_cnt = 0, hi_run = 0, lo_run = 0, hi_last = 0, lo_last = 0;
  int both_run = 0, gap_last = 0;
  logic [7:0] txb = 8'h00, auxb = 8'h00, rx_got = 8'h00;
  logic rx_seen = 1'b0;
  logic p_sclk = 1'b0, p_mosi = 1'b0, p_aux = 1'b1, p_s0 = 1'b1, p_s1 = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign miso = (edges < 8) ? miso_pat[3'(7 - edges)] : 1'b0;

  dbs_master dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_fast(cfg_fast),
    .cfg_sel(cfg_sel), .cfg_sel_hi(cfg_sel_hi), .cfg_hold(cfg_hold),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_data(rx_data), .sclk(sclk), .mosi(mosi),
    .aux(aux), .sel0_n(sel0_n), .sel1_n(sel1_n), .miso(miso)
  );

  always @(negedge clk) begin
    if (arm_tok != seen_tok) begin
      seen_tok = arm_tok; edges = 0; txb = 0; auxb = 0; stab_err = 0;
      sel_bad = 0; sel_rise = 0; ready_busy = 0; rx_cnt = 0; rx_seen = 0;
      hi_last = 0; lo_last = 0;
    end
    if (sclk && !p_sclk) begin
      if (edges > 0) lo_last = lo_run;
      edges++;
      txb  = {txb[6:0], mosi};
      auxb = {auxb[6:0], aux};
      if (sel0_n !== e0 || sel1_n !== e1) sel_bad++;
    end
    if (sclk) hi_run = p_sclk ? hi_run + 1 : 1;
    else if (p_sclk) begin hi_last = hi_run; lo_run = 1; end
    else lo_run++;
    if (sclk && p_sclk && (mosi !== p_mosi || aux !== p_aux)) stab_err++;
    if (sclk && tx_ready) ready_busy++;
    if ((sel0_n && !p_s0) || (sel1_n && !p_s1)) sel_rise++;
    if (sel0_n && sel1_n) both_run++;
    else begin
      if (p_s0 && p_s1) gap_last = both_run;
      both_run = 0;
    end
    if (rx_valid) begin rx_cnt++; rx_got = rx_data; rx_seen = 1'b1; end
    p_sclk = sclk; p_mosi = mosi; p_aux = aux; p_s0 = sel0_n; p_s1 = sel1_n;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] d, input logic f, input logic [1:0] s,
                      input logic ph, input logic h, input logic [7:0] dv,
                      input logic [7:0] pat);
    @(negedge clk);
    cfg_div = dv; cfg_fast = f; cfg_sel = s; cfg_sel_hi = ph; cfg_hold = h;
    tx_data = d; miso_pat = pat;
    e0 = !(!ph && s != 2'd2);
    e1 = !(!ph && s == 2'd2);
    arm_tok++;
    @(negedge clk);
    tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    check(tx_ready == 1'b0, "R8 ready low after accept", tx_ready, 0);
    while (!rx_seen) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [3:0] pick(input logic [7:0] v, input int off);
    logic [3:0] r;
    for (int i = 0; i < 4; i++) r[3-i] = v[7 - 2*i - off];
    return r;
  endfunction

  task automatic t_reset();
    check(sclk == 0 && mosi == 0, "R10 sclk/mosi idle", {sclk, mosi}, 0);
    check(aux == 1 && sel0_n == 1 && sel1_n == 1, "R10 aux/selects idle",
          {aux, sel0_n, sel1_n}, 3'b111);
    check(rx_valid == 0 && tx_ready == 1, "R10 handshake idle", {rx_valid, tx_ready}, 2'b01);
  endtask

  task automatic t_normal(input logic [7:0] d, input logic [1:0] s,
                          input logic [7:0] dv, input logic [7:0] pat);
    int half;
    half = ((dv == 0) ? 1 : int'(dv)) + 1;
    send(d, 1'b0, s, 1'b0, 1'b0, dv, pat);
    check(edges == 8, "R1 edge count", edges, 8);
    check(txb == d, "R1 msb-first data", txb, d);
    check(stab_err == 0, "R3 data held while high", stab_err, 0);
    check(sel_bad == 0, "R4 select decode", sel_bad, 0);
    check(sel0_n && sel1_n, "R5 release after byte", {sel0_n, sel1_n}, 3);
    check(hi_last == half && lo_last == half, "R6 half period", hi_last, half);
    check(rx_got == pat && rx_cnt == 1, "R7 received byte", rx_got, pat);
    check(ready_busy == 0, "R8 ready low while busy", ready_busy, 0);
  endtask

  task automatic t_fast(input logic [7:0] d, input logic [7:0] dv, input logic [7:0] pat);
    int half;
    half = ((dv == 0) ? 1 : int'(dv)) + 1;
    send(d, 1'b1, 2'd1, 1'b0, 1'b0, dv, pat);
    check(edges == 4, "R2 edge count", edges, 4);
    check(txb[3:0] == pick(d, 0), "R2 high bits on mosi", txb[3:0], pick(d, 0));
    check(auxb[3:0] == pick(d, 1), "R2 low bits on aux", auxb[3:0], pick(d, 1));
    check(stab_err == 0, "R3 pair held while high", stab_err, 0);
    check(hi_last == half, "R6 half period fast", hi_last, half);
    check(rx_got == {4'h0, pat[7:4]}, "R7 fast received nibble", rx_got, {4'h0, pat[7:4]});
    check(aux == 1'b1, "R2 aux idles high", aux, 1);
  endtask

  task automatic t_polhi();
    send(8'h5E, 1'b0, 2'd2, 1'b1, 1'b0, 8'd1, 8'h81);
    check(sel_bad == 0, "R4 active-high keeps selects high", sel_bad, 0);
    check(txb == 8'h5E, "R1 data with polarity high", txb, 8'h5E);
  endtask

  task automatic t_hold();
    send(8'h12, 1'b0, 2'd0, 1'b0, 1'b1, 8'd1, 8'hF0);
    check(sel0_n == 1'b0, "R5 select held after byte", sel0_n, 0);
    send(8'h34, 1'b0, 2'd0, 1'b0, 1'b1, 8'd1, 8'h0F);
    check(sel_rise == 0 && sel0_n == 1'b0, "R5 no release between held bytes", sel_rise, 0);
    check(txb == 8'h34 && rx_got == 8'h0F, "R1 second held byte", txb, 8'h34);
    @(negedge clk); cfg_hold = 1'b0;
    repeat (3) @(negedge clk);
    check(sel0_n && sel1_n, "R5 release when hold drops", {sel0_n, sel1_n}, 3);
  endtask

  task automatic t_gap();
    send(8'hC3, 1'b0, 2'd2, 1'b0, 1'b0, 8'd1, 8'h11);
    send(8'h3C, 1'b0, 2'd2, 1'b0, 1'b0, 8'd1, 8'h22);
    check(gap_last >= GAP_EXP, "R9 idle gap between selects", gap_last, GAP_EXP);
    check(sel_bad == 0, "R4 select index 2", sel_bad, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_normal(8'hA5, 2'd0, 8'd3, 8'h5A);
    t_normal(8'h3C, 2'd2, 8'd0, 8'hC6);
    t_fast(8'hB4, 8'd1, 8'hC3);
    t_fast(8'h69, 8'd0, 8'h9F);
    t_polhi();
    t_hold();
    t_gap();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule